// File: doc/BRIEF.md
# Register Pending-Write Interlock

This block holds the interlock state of an in-order pipelined processor. Each architectural register has one flag saying whether its contents can be used. A register that an instruction leaving decode will write is marked unavailable. It becomes available again when that instruction writes back its result.

The decode stage presents up to two source register numbers and one destination register number. Each number has its own use-enable, and an issue strobe marks a real instruction. The block answers with a single combinational stall signal. A stall is raised when any enabled operand, the destination included, names an unavailable register. Every kind of dependence therefore holds the instruction in decode: read-after-write, write-after-read and write-after-write. A result written back in the same cycle counts as already available. Register 0 never causes a stall.

Top module: `regfile_interlock`

## Requirements
- R1: After the synchronous active-low reset, every register is available, so an issued instruction using any registers sees stall low.
- R2: An instruction issued without stall, with its destination enabled and a destination other than 0, makes that register unavailable from the next cycle.
- R3: A writeback strobe makes the written register available again from the next cycle.
- R4: With the issue strobe high, stall is high whenever an enabled source operand names an unavailable register that is not being written back in the same cycle.
- R5: With the issue strobe high, stall is high whenever the enabled destination names an unavailable register that is not being written back in the same cycle.
- R6: An operand whose use-enable is low never causes a stall, whatever register number it carries.
- R7: A register written back in the same cycle that decode examines it counts as available for that decision.
- R8: While stall is high, the stalled instruction makes no register unavailable.
- R9: Register 0 is always available. Issuing an instruction with destination 0 never makes it unavailable.
- R10: With the issue strobe low, stall is low and no register is made unavailable.
- R11: When writeback and a new issue without stall target the same register in one cycle, the register is unavailable in the next cycle, because the new writer is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_issue | input | 1 | Decode holds an instruction that wants to leave this cycle |
| dec_src_a | input | 5 | First source register number |
| dec_src_a_use | input | 1 | First source is read |
| dec_src_b | input | 5 | Second source register number |
| dec_src_b_use | input | 1 | Second source is read |
| dec_dst | input | 5 | Destination register number |
| dec_dst_use | input | 1 | Instruction writes a register |
| wb_dst | input | 5 | Register written back this cycle |
| wb_wen | input | 1 | Writeback strobe |
| stall | output | 1 | Hold the instruction in decode |

## Verification
The assertions check on every cycle that a stall appears only with an issued instruction, that an enabled source or destination blocked in the flag array raises it, and that instructions using only register 0 pass. They also check that a stalled cycle leaves no flag cleared, and that issue and writeback move the addressed flag on the next edge. Some behaviours are visible only through instruction sequences that the bench's scenarios build. These are the same-cycle writeback bypass, the case where a new writer and a retiring writer hit the same register (clear wins), and the fact that disabled operands carrying blocked register numbers are ignored.

// File: rtl/ilk_pkg.sv
// Package: shared constants and operand-slot enumeration for the
// register interlock. Assumes an architectural register file whose size
// is a power of two.
package ilk_pkg;
    localparam int unsigned DEFAULT_REGS = 32;

    // Operand slots checked by decode; destination is checked like a source.
    typedef enum logic [1:0] {
        SLOT_SRC_A = 2'd0,
        SLOT_SRC_B = 2'd1,
        SLOT_DST   = 2'd2
    } op_slot_e;

    localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/ilk_flag_array.sv
// Module: one availability flag per register.
// Set on writeback, cleared on issue of a new writer; clear wins when both
// address the same register. Register 0 is tied available.
// Assumes clr_idx is never 0 when clr_en is high (top guarantees this).
module ilk_flag_array #(
    parameter int unsigned NUM_REGS = ilk_pkg::DEFAULT_REGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] avail
);
    assign avail[0] = 1'b1;

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_flag
        // Per-register flag: reset available, clear beats set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                avail[r] <= 1'b1;
            end else if (clr_en && (clr_idx == IDX_W'(r))) begin
                avail[r] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(r))) begin
                avail[r] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ilk_operand_probe.sv
// Module: decides whether one decode operand is blocked.
// An operand is blocked when enabled and its register is neither available
// nor being written back this cycle. Purely combinational.
module ilk_operand_probe #(
    parameter int unsigned NUM_REGS = ilk_pkg::DEFAULT_REGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] avail,
    input  logic                use_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic                wb_wen,
    input  logic [IDX_W-1:0]    wb_dst,
    output logic                blocked
);
    logic bypass_hit;

    // Writeback in the same cycle makes the register look available.
    always_comb begin
        bypass_hit = wb_wen && (wb_dst == idx);
        blocked    = use_en && !(avail[idx] || bypass_hit);
    end
endmodule

// File: rtl/regfile_interlock.sv
// Module: register pending-write interlock for an in-order pipeline.
// Checks both sources and the destination of the decoding instruction
// against per-register availability flags and raises stall on any hit.
// Assumes decode holds its inputs steady while stall is high.
module regfile_interlock #(
    parameter int unsigned NUM_REGS = ilk_pkg::DEFAULT_REGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_issue,
    input  logic [IDX_W-1:0] dec_src_a,
    input  logic             dec_src_a_use,
    input  logic [IDX_W-1:0] dec_src_b,
    input  logic             dec_src_b_use,
    input  logic [IDX_W-1:0] dec_dst,
    input  logic             dec_dst_use,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_wen,
    output logic             stall
);
    import ilk_pkg::*;

    logic [NUM_REGS-1:0]  avail;
    logic [IDX_W-1:0]     slot_idx [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_use;
    logic [NUM_SLOTS-1:0] slot_blk;
    logic                 mark_pending;

    // Gather operand slots into arrays for the probe generate loop.
    always_comb begin
        slot_idx[SLOT_SRC_A] = dec_src_a;
        slot_idx[SLOT_SRC_B] = dec_src_b;
        slot_idx[SLOT_DST]   = dec_dst;
        slot_use[SLOT_SRC_A] = dec_src_a_use;
        slot_use[SLOT_SRC_B] = dec_src_b_use;
        slot_use[SLOT_DST]   = dec_dst_use;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_probe
        ilk_operand_probe #(.NUM_REGS(NUM_REGS)) u_probe (
            .avail   (avail),
            .use_en  (slot_use[s]),
            .idx     (slot_idx[s]),
            .wb_wen  (wb_wen),
            .wb_dst  (wb_dst),
            .blocked (slot_blk[s])
        );
    end

    // Stall decision and the clear request for an instruction that leaves.
    always_comb begin
        stall        = dec_issue && (|slot_blk);
        mark_pending = dec_issue && !stall && dec_dst_use && (dec_dst != '0);
    end

    ilk_flag_array #(.NUM_REGS(NUM_REGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (wb_wen),
        .set_idx (wb_dst),
        .clr_en  (mark_pending),
        .clr_idx (dec_dst),
        .avail   (avail)
    );

    // R10
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_issue |-> !stall);

    // R4
    src_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_issue && dec_src_a_use && !avail[dec_src_a]
         && !(wb_wen && wb_dst == dec_src_a)) |-> stall);

    // R5
    dst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_issue && dec_dst_use && !avail[dec_dst]
         && !(wb_wen && wb_dst == dec_dst)) |-> stall);

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_issue && (!dec_src_a_use || dec_src_a == '0)
         && (!dec_src_b_use || dec_src_b == '0)
         && (!dec_dst_use || dec_dst == '0)) |-> !stall);

    // R8
    stall_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wb_wen) |=> $stable(avail));

    // R2
    issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_issue && !stall && dec_dst_use && dec_dst != '0)
        |=> !avail[$past(dec_dst)]);

    // R3
    wb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wen && !(dec_issue && !stall && dec_dst_use && dec_dst == wb_dst))
        |=> avail[$past(wb_dst)]);
endmodule

// File: tb/regfile_interlock_test.sv
module regfile_interlock_test;
    localparam int NREG = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_issue = 1'b0;
    logic [4:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0, wb_dst = '0;
    logic       dec_src_a_use = 1'b0, dec_src_b_use = 1'b0, dec_dst_use = 1'b0;
    logic       wb_wen = 1'b0;
    logic       stall;

    int checks = 0;
    int fails  = 0;
    bit pend [NREG];

    always #4 clk = ~clk;

    regfile_interlock uut (
        .clk(clk), .rst_n(rst_n), .dec_issue(dec_issue),
        .dec_src_a(dec_src_a), .dec_src_a_use(dec_src_a_use),
        .dec_src_b(dec_src_b), .dec_src_b_use(dec_src_b_use),
        .dec_dst(dec_dst), .dec_dst_use(dec_dst_use),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .stall(stall)
    );

    function automatic bit ready(int r, bit ww, int wd);
        return (r == 0) || !pend[r] || (ww && wd == r);
    endfunction

    // One cycle: drive at negedge, compare mid-cycle, update model after edge.
    task automatic step(int a, bit ua, int b, bit ub, int d, bit ud, bit iss,
                        int wd, bit ww, int hint, string req);
        bit exp;
        dec_src_a = 5'(a); dec_src_a_use = ua;
        dec_src_b = 5'(b); dec_src_b_use = ub;
        dec_dst = 5'(d); dec_dst_use = ud; dec_issue = iss;
        wb_dst = 5'(wd); wb_wen = ww;
        #2;
        exp = iss && ((ua && !ready(a, ww, wd)) || (ub && !ready(b, ww, wd))
                      || (ud && !ready(d, ww, wd)));
        checks++;
        if (stall !== exp) begin
            fails++;
            $display("FAIL %s: stall actual %0b expected %0b", req, stall, exp);
        end
        if (hint >= 0) begin
            checks++;
            if (stall !== 1'(hint)) begin
                fails++;
                $display("FAIL %s: stall actual %0b expected %0d", req, stall, hint);
            end
        end
        @(posedge clk);
        #1;
        if (ww) pend[wd] = 1'b0;
        if (iss && !exp && ud && d != 0) pend[d] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(64'd8 * 200000);
        fails++;
        $display("FAIL WDOG: run did not end, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        foreach (pend[i]) pend[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register available after reset
        step(1, 1, 2, 1, 3, 0, 1, 0, 0, 0, "R1");
        step(31, 1, 30, 1, 0, 0, 1, 0, 0, 0, "R1");
        // R2: writer of r5 leaves, r5 now pending
        step(0, 0, 0, 0, 5, 1, 1, 0, 0, 0, "R2");
        // R4: reader of r5 stalls; its dst r7 must not be marked (R8)
        step(5, 1, 0, 0, 7, 1, 1, 0, 0, 1, "R4");
        step(0, 0, 5, 1, 0, 0, 1, 0, 0, 1, "R4");
        // R8: r7 still available
        step(7, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        // R6: disabled operands naming r5 are ignored
        step(5, 0, 5, 0, 5, 0, 1, 0, 0, 0, "R6");
        // R5: write-after-write on r5 stalls
        step(0, 0, 0, 0, 5, 1, 1, 0, 0, 1, "R5");
        // R10: no issue, no stall, nothing marked
        step(5, 1, 5, 1, 9, 1, 0, 0, 0, 0, "R10");
        step(9, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
        // R7: writeback of r5 in the same cycle passes the reader
        step(5, 1, 0, 0, 0, 0, 1, 5, 1, 0, "R7");
        // R3: r5 available after writeback
        step(5, 1, 5, 1, 0, 0, 1, 0, 0, 0, "R3");
        // R11: retire and new writer of r6 together leave r6 pending
        step(0, 0, 0, 0, 6, 1, 1, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 6, 1, 1, 6, 1, 0, "R11");
        step(6, 1, 0, 0, 0, 0, 1, 0, 0, 1, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 6, 1, 0, "R3");
        step(6, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        // R9: destination r0 never marked pending
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
        step(0, 1, 0, 1, 0, 1, 1, 0, 0, 0, "R9");
        // Mixed traffic on a small register window
        for (int n = 0; n < 3000; n++) begin
            step(int'($urandom_range(0, 7)), 1'($urandom), int'($urandom_range(0, 7)),
                 1'($urandom), int'($urandom_range(0, 7)), 1'($urandom),
                 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 2) == 0), -1, "R4/R5 mixed");
        end
        // R1: reset again restores availability
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        foreach (pend[i]) pend[i] = 1'b0;
        step(1, 1, 2, 1, 3, 1, 1, 0, 0, 0, "R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule